// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Operation Decoder

This block pairs a purely combinational integer arithmetic/logic unit with the small decoder that chooses its operation. A main controller supplies a 2-bit operation class. For register-to-register instructions it also supplies the 6-bit function field taken from the instruction word. The decoder turns these into a 4-bit operation select. The unit applies that operation to two operands and drives a result word and a zero flag.

Load/store address generation uses the class that forces an add. Branch comparison uses the class that forces a subtract and reads the zero flag as "operands equal". Arithmetic instructions let the function field pick among add, subtract, AND, OR, NOR and set-on-less-than. The block holds no state, so outputs follow the inputs within the same cycle.

Top module: `alu_fn_unit`

## Requirements
- R1: With operation class 2'b00, the operation select is 4'b0010 (add), whatever the function field holds.
- R2: With operation class 2'b01, the operation select is 4'b0110 (subtract), whatever the function field holds.
- R3: With operation class 2'b10, these function fields map to these selects: 6'b100000 to 4'b0010 (add), 6'b100010 to 4'b0110 (subtract), 6'b100100 to 4'b0000 (AND), 6'b100101 to 4'b0001 (OR), 6'b101010 to 4'b0111 (set-on-less-than), and 6'b100111 to 4'b1100 (NOR).
- R4: With operation class 2'b10, any function field not listed in R3 gives the add select 4'b0010.
- R5: Operation class 2'b11 decodes exactly like class 2'b10.
- R6: AND, OR and NOR selects produce the bitwise AND, OR and inverted OR of the two operands.
- R7: Add and subtract wrap modulo 2^WIDTH and give no overflow indication.
- R8: Set-on-less-than compares the operands as signed two's-complement values. It returns 1 in bit 0 when a < b and 0 otherwise, and all higher result bits are zero.
- R9: The zero output is 1 exactly when every result bit is 0. After a subtract, this means the operands are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op_sel | output | 4 | Decoded operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench sweeps every operation class against all 64 function codes. A decoder that ignored the class, mishandled class 2'b11, or let an unlisted code fall to something other than add shows up as a wrong select. Signed set-on-less-than is tested with operands of opposite sign and at the most negative value; an unsigned compare would invert those outcomes. Wrap-around sums such as all-ones plus one are tested to catch a zero flag or result that depends on a carry-out. Equal-operand subtracts are tested to catch a zero flag that is stuck or inverted.

// File: rtl/alu_fn_unit.sv
module alu_fn_unit #(
  parameter int WIDTH = 32,
  parameter int FW    = 6
) (
  input  logic [1:0]       op_class,
  input  logic [FW-1:0]    funct,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  localparam logic [3:0] SEL_AND = 4'b0000;
  localparam logic [3:0] SEL_OR  = 4'b0001;
  localparam logic [3:0] SEL_ADD = 4'b0010;
  localparam logic [3:0] SEL_SUB = 4'b0110;
  localparam logic [3:0] SEL_SLT = 4'b0111;
  localparam logic [3:0] SEL_NOR = 4'b1100;

  localparam logic [FW-1:0] FN_ADD = FW'(6'b100000);
  localparam logic [FW-1:0] FN_SUB = FW'(6'b100010);
  localparam logic [FW-1:0] FN_AND = FW'(6'b100100);
  localparam logic [FW-1:0] FN_OR  = FW'(6'b100101);
  localparam logic [FW-1:0] FN_SLT = FW'(6'b101010);
  localparam logic [FW-1:0] FN_NOR = FW'(6'b100111);

  logic [WIDTH-1:0] diff;
  logic             less;

  always_comb begin
    op_sel = SEL_ADD;
    if (op_class == 2'b01) begin
      op_sel = SEL_SUB;
    end else if (op_class[1]) begin
      case (funct)
        FN_ADD:  op_sel = SEL_ADD;
        FN_SUB:  op_sel = SEL_SUB;
        FN_AND:  op_sel = SEL_AND;
        FN_OR:   op_sel = SEL_OR;
        FN_SLT:  op_sel = SEL_SLT;
        FN_NOR:  op_sel = SEL_NOR;
        default: op_sel = SEL_ADD;
      endcase
    end
  end

  assign diff = a - b;
  assign less = (a[WIDTH-1] != b[WIDTH-1]) ? a[WIDTH-1] : diff[WIDTH-1];

  always_comb begin
    case (op_sel)
      SEL_AND: result = a & b;
      SEL_OR:  result = a | b;
      SEL_SUB: result = diff;
      SEL_SLT: result = {{(WIDTH-1){1'b0}}, less};
      SEL_NOR: result = ~(a | b);
      default: result = a + b;
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    // R1
    if (op_class == 2'b00) class_ls_add_chk: assert (op_sel == SEL_ADD)
      else $error("class 00 did not force add");
    // R2
    if (op_class == 2'b01) class_br_sub_chk: assert (op_sel == SEL_SUB)
      else $error("class 01 did not force subtract");
    // R8
    if (op_sel == SEL_SLT) slt_upper_clear_chk: assert (result[WIDTH-1:1] == '0)
      else $error("set-on-less-than upper bits not clear");
    // R9
    if (op_sel == SEL_SUB) sub_zero_eq_chk: assert (zero == (a == b))
      else $error("zero flag disagrees with operand equality");
    // R6
    if (op_sel == SEL_NOR) nor_disjoint_chk: assert ((result & (a | b)) == '0)
      else $error("NOR result overlaps operand ones");
  end

endmodule

// File: tb/tb_alu_fn_unit.sv
module tb_alu_fn_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [1:0]   op_class = 2'b00;
  logic [5:0]   funct = 6'd0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [3:0]   op_sel;
  logic [W-1:0] result;
  logic         zero;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_fn_unit dut (
    .op_class(op_class), .funct(funct), .a(a), .b(b),
    .op_sel(op_sel), .result(result), .zero(zero)
  );

  function automatic logic [3:0] exp_sel(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 4'b0010;
    if (c == 2'b01) return 4'b0110;
    case (f)
      6'h20: return 4'b0010;
      6'h22: return 4'b0110;
      6'h24: return 4'b0000;
      6'h25: return 4'b0001;
      6'h2a: return 4'b0111;
      6'h27: return 4'b1100;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_res(input logic [3:0] s, input logic [W-1:0] x, input logic [W-1:0] y);
    longint sx, sy;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (s)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0110: return W'((longint'(x) - longint'(y)) & 64'hFFFF_FFFF);
      4'b0111: return (sx < sy) ? W'(1) : W'(0);
      4'b1100: return ~(x | y);
      default: return W'((longint'(x) + longint'(y)) & 64'hFFFF_FFFF);
    endcase
  endfunction

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    logic [3:0]   es;
    logic [W-1:0] er;
    @(posedge clk);
    op_class = c; funct = f; a = x; b = y;
    es = exp_sel(c, f);
    er = exp_res(es, x, y);
    @(negedge clk);
    checks++;
    if (op_sel !== es) begin
      failures++;
      $display("FAIL %s op_sel actual=%b expected=%b (class=%b funct=%b)", tag, op_sel, es, c, f);
    end
    checks++;
    if (result !== er) begin
      failures++;
      $display("FAIL %s result actual=%h expected=%h (sel=%b a=%h b=%h)", tag, result, er, es, x, y);
    end
    checks++;
    if (zero !== (er == '0)) begin
      failures++;
      $display("FAIL R9 zero actual=%b expected=%b (tag %s)", zero, (er == '0), tag);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset-like state: all inputs zero -> add, result 0, zero high (R1, R9)
    @(negedge clk);
    checks++;
    if (op_sel !== 4'b0010 || result !== '0 || zero !== 1'b1) begin
      failures++;
      $display("FAIL R1 idle state actual=%b/%h/%b expected=0010/0/1", op_sel, result, zero);
    end

    // exhaustive class x funct sweep: R1 R2 R3 R4 R5
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 64; f++) begin
        apply(2'(c), 6'(f), $urandom(), $urandom(), "R3_R4_R5_sweep");
      end
    end

    // R6 logic patterns
    apply(2'b10, 6'h24, 32'hF0F0_F0F0, 32'hFF00_FF00, "R6_and");
    apply(2'b10, 6'h25, 32'h0F0F_0000, 32'h0000_00F0, "R6_or");
    apply(2'b11, 6'h27, 32'h0000_0000, 32'h0000_0000, "R6_nor_zero_in");
    apply(2'b10, 6'h27, 32'hFFFF_0000, 32'h0000_FFFF, "R6_nor_all_ones");

    // R7 wrap
    apply(2'b00, 6'h3f, 32'hFFFF_FFFF, 32'h0000_0001, "R7_add_wrap");
    apply(2'b10, 6'h22, 32'h0000_0000, 32'h0000_0001, "R7_sub_wrap");
    apply(2'b10, 6'h20, 32'h7FFF_FFFF, 32'h0000_0001, "R7_add_signed_ovf");
    apply(2'b10, 6'h22, 32'h8000_0000, 32'h0000_0001, "R7_sub_signed_ovf");

    // R8 signed compare
    apply(2'b10, 6'h2a, 32'h8000_0000, 32'h0000_0001, "R8_minneg_lt_pos");
    apply(2'b10, 6'h2a, 32'h0000_0001, 32'h8000_0000, "R8_pos_not_lt_neg");
    apply(2'b10, 6'h2a, 32'hFFFF_FFFF, 32'h0000_0000, "R8_minus1_lt_0");
    apply(2'b10, 6'h2a, 32'h0000_0005, 32'h0000_0005, "R8_equal");
    apply(2'b10, 6'h2a, 32'h7FFF_FFFF, 32'h8000_0000, "R8_max_vs_min");
    apply(2'b11, 6'h2a, 32'h0000_0003, 32'h0000_0009, "R8_small");

    // R9 / R2 branch equality
    apply(2'b01, 6'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R9_branch_equal");
    apply(2'b01, 6'h2a, 32'hDEAD_BEEF, 32'hDEAD_BEEE, "R9_branch_unequal");

    // random vectors across all classes and known codes
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] fsel;
      case ($urandom_range(0, 6))
        0: fsel = 6'h20; 1: fsel = 6'h22; 2: fsel = 6'h24;
        3: fsel = 6'h25; 4: fsel = 6'h2a; 5: fsel = 6'h27;
        default: fsel = 6'($urandom());
      endcase
      apply(2'($urandom()), fsel, $urandom(), ($urandom_range(0, 7) == 0) ? a : $urandom(), "R6_R7_R8_random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule